// File: doc/BRIEF.md
# Configuration Context Preloader

This controller sits between a context store and a two-layer reconfigurable cell array. A processor starts it with a first context index and a sequence length. The controller then streams each 128-word context out of the store, one read per cycle. It decodes every word into either a cell configuration write or a constant write to the global or local register storage. Cell configuration writes always go to the layer the array is not currently executing from.

Preloading is hidden behind execution. When a context is fully written and the array reports that its current context has finished, the controller flips the active layer and pulses a start strobe in the next cycle, with no reconfiguration gap. It then immediately begins preloading the following context of the sequence. A completion pulse marks the end of the final context's execution.

Top module: `ctx_preloader`

## Requirements
- R1: Context memory reads are issued one per cycle, 128 per context, at address {context index, word index}, where the context index is in the upper bits and the word index counts 0 to 127 in the lower 7 bits. Context indices advance by one per context and wrap modulo 16.
- R2: Each word is decoded on bits [31:30]: 00 is a cell configuration write with cell select [29:24] and payload [23:0]; 01 is a global-register constant write; 10 is a local-register constant write (for both, select [29:24] and payload [23:0]); 11 produces no write. At most one write is issued per word.
- R3: Every cell configuration write targets the inactive layer, so `cfg_layer_o` is the inverse of `active_layer_o`.
- R4: A word's write appears on the outputs two cycles after its read is issued.
- R5: A layer swap flips `active_layer_o` and pulses `ctx_go_o` for one cycle. It happens only after all 128 words of the context have been written. With the array idle, the swap comes three cycles after the last read. Without a finish report from a running array, no swap occurs.
- R6: If `exec_done_i` arrives while the next context is already fully written, `ctx_go_o` rises in the very next cycle.
- R7: A finish report that arrives during preloading is remembered, and the swap follows as soon as preloading completes. That is 130 cycles after the previous swap.
- R8: After a swap that leaves contexts still pending, preloading of the next context index begins at once.
- R9: `seq_done_o` pulses for one cycle, in the cycle after `exec_done_i` reports the end of the final context of the sequence.
- R10: `start_i` is ignored while a sequence is in progress, and also when `seq_len_i` is zero.
- R11: After reset, no reads or writes are issued, `active_layer_o` is 0, and both pulses are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Processor start strobe |
| seq_base_i | input | 4 | First context index of the sequence |
| seq_len_i | input | 5 | Number of contexts in the sequence |
| exec_done_i | input | 1 | Array finished its current context |
| cm_rd_en_o | output | 1 | Context memory read enable |
| cm_rd_addr_o | output | 11 | Context memory word address |
| cm_rd_data_i | input | 32 | Read data, valid one cycle after the read |
| cfg_we_o | output | 1 | Cell configuration write strobe |
| cfg_layer_o | output | 1 | Layer the configuration write targets |
| cfg_cell_o | output | 6 | Cell select |
| cfg_data_o | output | 24 | Configuration payload |
| const_we_o | output | 1 | Constant write strobe |
| const_local_o | output | 1 | 1 = local register, 0 = global register file |
| const_addr_o | output | 6 | Constant register select |
| const_data_o | output | 24 | Constant value |
| ctx_go_o | output | 1 | Layer swap / new context start pulse |
| active_layer_o | output | 1 | Layer the array executes from |
| seq_done_o | output | 1 | Sequence completion pulse |

## Verification
The assertions check several properties on every cycle: configuration writes never hit the executing layer, a word never produces both kinds of write, read addresses step by one while reads are back to back, and the active layer changes only together with a one-cycle swap pulse. Only the directed scenarios can show the rest. These are the exact latencies from read to write and from last read to swap, the zero-gap swap on a late finish report, the remembered early finish report, the decode counts and payload sums per context, address wrap across the last context index, and the ignored start requests.

// File: rtl/ctxpre_pkg.sv
package ctxpre_pkg;

    localparam int KIND_W = 2;

    typedef enum logic [1:0] {
        WK_CELL = 2'b00,
        WK_GREG = 2'b01,
        WK_LREG = 2'b10,
        WK_SKIP = 2'b11
    } word_kind_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_LOAD,
        ST_DRAIN
    } seq_state_e;

endpackage

// File: rtl/ctxpre_fetch.sv
module ctxpre_fetch #(
    parameter int CTX_IDX_W = 4,
    parameter int CTX_WORDS = 128
) (
    input  logic                                        clk,
    input  logic                                        rst_n,
    input  logic                                        start_i,
    input  logic [CTX_IDX_W-1:0]                        ctx_i,
    output logic                                        rd_en_o,
    output logic [CTX_IDX_W+$clog2(CTX_WORDS)-1:0]      rd_addr_o,
    output logic                                        rd_last_o
);
    localparam int WIDX_W = $clog2(CTX_WORDS);
    localparam logic [WIDX_W-1:0] LAST_IDX = WIDX_W'(CTX_WORDS - 1);

    typedef struct packed {
        logic                 busy;
        logic [CTX_IDX_W-1:0] ctx;
        logic [WIDX_W-1:0]    cnt;
    } fetch_regs_t;

    fetch_regs_t fr_d, fr_q;
    logic at_end;

    assign at_end = fr_q.busy && (fr_q.cnt == LAST_IDX);

    always_comb begin
        fr_d = fr_q;
        if (fr_q.busy) begin
            fr_d.cnt = fr_q.cnt + 1'b1;
            if (at_end) begin
                fr_d.busy = 1'b0;
                fr_d.cnt  = '0;
            end
        end
        if (start_i) begin
            fr_d.busy = 1'b1;
            fr_d.ctx  = ctx_i;
            fr_d.cnt  = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) fr_q <= '0;
        else        fr_q <= fr_d;
    end

    assign rd_en_o   = fr_q.busy;
    assign rd_addr_o = {fr_q.ctx, fr_q.cnt};
    assign rd_last_o = at_end;

endmodule

// File: rtl/ctxpre_decode.sv
module ctxpre_decode
    import ctxpre_pkg::*;
#(
    parameter int WORD_W = 32,
    parameter int SEL_W  = 6
) (
    input  logic                             valid_i,
    input  logic [WORD_W-1:0]                word_i,
    output logic                             cell_we_o,
    output logic                             const_we_o,
    output logic                             const_local_o,
    output logic [SEL_W-1:0]                 sel_o,
    output logic [WORD_W-KIND_W-SEL_W-1:0]   payload_o
);
    localparam int PAY_W = WORD_W - KIND_W - SEL_W;

    word_kind_e kind;

    assign kind      = word_kind_e'(word_i[WORD_W-1 -: KIND_W]);
    assign sel_o     = word_i[PAY_W +: SEL_W];
    assign payload_o = word_i[PAY_W-1:0];

    always_comb begin
        cell_we_o     = 1'b0;
        const_we_o    = 1'b0;
        const_local_o = 1'b0;
        if (valid_i) begin
            case (kind)
                WK_CELL: cell_we_o = 1'b1;
                WK_GREG: const_we_o = 1'b1;
                WK_LREG: begin
                    const_we_o    = 1'b1;
                    const_local_o = 1'b1;
                end
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/ctx_preloader.sv
module ctx_preloader
    import ctxpre_pkg::*;
#(
    parameter int CTX_IDX_W = 4,
    parameter int CTX_WORDS = 128,
    parameter int WORD_W    = 32,
    parameter int SEL_W     = 6
) (
    input  logic                                       clk,
    input  logic                                       rst_n,
    input  logic                                       start_i,
    input  logic [CTX_IDX_W-1:0]                       seq_base_i,
    input  logic [CTX_IDX_W:0]                         seq_len_i,
    input  logic                                       exec_done_i,
    output logic                                       cm_rd_en_o,
    output logic [CTX_IDX_W+$clog2(CTX_WORDS)-1:0]     cm_rd_addr_o,
    input  logic [WORD_W-1:0]                          cm_rd_data_i,
    output logic                                       cfg_we_o,
    output logic                                       cfg_layer_o,
    output logic [SEL_W-1:0]                           cfg_cell_o,
    output logic [WORD_W-KIND_W-SEL_W-1:0]             cfg_data_o,
    output logic                                       const_we_o,
    output logic                                       const_local_o,
    output logic [SEL_W-1:0]                           const_addr_o,
    output logic [WORD_W-KIND_W-SEL_W-1:0]             const_data_o,
    output logic                                       ctx_go_o,
    output logic                                       active_layer_o,
    output logic                                       seq_done_o
);
    localparam int PAY_W = WORD_W - KIND_W - SEL_W;
    localparam int LEN_W = CTX_IDX_W + 1;

    typedef struct packed {
        seq_state_e           state;
        logic [CTX_IDX_W-1:0] ctx;
        logic [LEN_W-1:0]     left;
        logic                 running;
        logic                 pend;
        logic                 loaded;
        logic                 rd_v;
        logic                 rd_last;
        logic                 layer;
        logic                 go;
        logic                 done;
        logic                 cfg_we;
        logic                 cfg_layer;
        logic [SEL_W-1:0]     cfg_cell;
        logic [PAY_W-1:0]     cfg_data;
        logic                 const_we;
        logic                 const_local;
        logic [SEL_W-1:0]     const_addr;
        logic [PAY_W-1:0]     const_data;
    } ctl_regs_t;

    ctl_regs_t r_d, r_q;

    logic                 fetch_start;
    logic [CTX_IDX_W-1:0] fetch_ctx;
    logic                 fetch_rd_en;
    logic                 fetch_last;
    logic                 dec_cell_we;
    logic                 dec_const_we;
    logic                 dec_const_local;
    logic [SEL_W-1:0]     dec_sel;
    logic [PAY_W-1:0]     dec_payload;
    logic                 swap_ok;

    ctxpre_fetch #(
        .CTX_IDX_W (CTX_IDX_W),
        .CTX_WORDS (CTX_WORDS)
    ) u_fetch (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_i   (fetch_start),
        .ctx_i     (fetch_ctx),
        .rd_en_o   (fetch_rd_en),
        .rd_addr_o (cm_rd_addr_o),
        .rd_last_o (fetch_last)
    );

    ctxpre_decode #(
        .WORD_W (WORD_W),
        .SEL_W  (SEL_W)
    ) u_decode (
        .valid_i       (r_q.rd_v),
        .word_i        (cm_rd_data_i),
        .cell_we_o     (dec_cell_we),
        .const_we_o    (dec_const_we),
        .const_local_o (dec_const_local),
        .sel_o         (dec_sel),
        .payload_o     (dec_payload)
    );

    // Swap needs a fully written layer and an array that is idle or just finished.
    assign swap_ok = r_q.loaded && (!r_q.running || r_q.pend || exec_done_i);

    always_comb begin
        r_d         = r_q;
        r_d.go      = 1'b0;
        r_d.done    = 1'b0;
        r_d.rd_v    = fetch_rd_en;
        r_d.rd_last = fetch_last;
        fetch_start = 1'b0;
        fetch_ctx   = r_q.ctx + 1'b1;

        // Registered write outputs, one per returned word.
        r_d.cfg_we      = dec_cell_we;
        r_d.cfg_layer   = ~r_q.layer;
        r_d.cfg_cell    = dec_sel;
        r_d.cfg_data    = dec_payload;
        r_d.const_we    = dec_const_we;
        r_d.const_local = dec_const_local;
        r_d.const_addr  = dec_sel;
        r_d.const_data  = dec_payload;

        if (r_q.rd_last) r_d.loaded = 1'b1;

        case (r_q.state)
            ST_IDLE: begin
                if (start_i && (seq_len_i != '0)) begin
                    r_d.state   = ST_LOAD;
                    r_d.ctx     = seq_base_i;
                    r_d.left    = seq_len_i - 1'b1;
                    r_d.loaded  = 1'b0;
                    r_d.pend    = 1'b0;
                    fetch_start = 1'b1;
                    fetch_ctx   = seq_base_i;
                end
            end
            ST_LOAD: begin
                if (r_q.running && exec_done_i) r_d.pend = 1'b1;
                if (swap_ok) begin
                    r_d.go      = 1'b1;
                    r_d.layer   = ~r_q.layer;
                    r_d.running = 1'b1;
                    r_d.pend    = 1'b0;
                    r_d.loaded  = 1'b0;
                    if (r_q.left != '0) begin
                        r_d.left    = r_q.left - 1'b1;
                        r_d.ctx     = r_q.ctx + 1'b1;
                        fetch_start = 1'b1;
                    end else begin
                        r_d.state = ST_DRAIN;
                    end
                end
            end
            ST_DRAIN: begin
                if (exec_done_i) begin
                    r_d.done    = 1'b1;
                    r_d.running = 1'b0;
                    r_d.state   = ST_IDLE;
                end
            end
            default: r_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q       <= '0;
            r_q.state <= ST_IDLE;
        end else begin
            r_q <= r_d;
        end
    end

    assign cm_rd_en_o     = fetch_rd_en;
    assign cfg_we_o       = r_q.cfg_we;
    assign cfg_layer_o    = r_q.cfg_layer;
    assign cfg_cell_o     = r_q.cfg_cell;
    assign cfg_data_o     = r_q.cfg_data;
    assign const_we_o     = r_q.const_we;
    assign const_local_o  = r_q.const_local;
    assign const_addr_o   = r_q.const_addr;
    assign const_data_o   = r_q.const_data;
    assign ctx_go_o       = r_q.go;
    assign active_layer_o = r_q.layer;
    assign seq_done_o     = r_q.done;

endmodule

// File: rtl/ctx_preloader_chk.sv
module ctx_preloader_chk #(
    parameter int ADDR_W = 11
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cm_rd_en_o,
    input logic [ADDR_W-1:0] cm_rd_addr_o,
    input logic              cfg_we_o,
    input logic              cfg_layer_o,
    input logic              const_we_o,
    input logic              ctx_go_o,
    input logic              active_layer_o,
    input logic              seq_done_o
);
    logic past_ok_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) past_ok_q <= 1'b0;
        else        past_ok_q <= 1'b1;
    end

    assert_rd_step_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok_q && cm_rd_en_o && $past(cm_rd_en_o))
            |-> (cm_rd_addr_o == ADDR_W'($past(cm_rd_addr_o) + 1'b1)));

    assert_one_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !(cfg_we_o && const_we_o));

    assert_inactive_layer_R3: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_we_o |-> (cfg_layer_o != active_layer_o));

    assert_swap_flips_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok_q && ctx_go_o) |-> (active_layer_o != $past(active_layer_o)));

    assert_layer_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok_q && !ctx_go_o) |-> $stable(active_layer_o));

    assert_go_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ctx_go_o |=> !ctx_go_o);

    assert_done_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
        seq_done_o |=> !seq_done_o);

    assert_done_no_go_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !(seq_done_o && ctx_go_o));

endmodule

bind ctx_preloader ctx_preloader_chk #(
    .ADDR_W (CTX_IDX_W + $clog2(CTX_WORDS))
) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .cm_rd_en_o     (cm_rd_en_o),
    .cm_rd_addr_o   (cm_rd_addr_o),
    .cfg_we_o       (cfg_we_o),
    .cfg_layer_o    (cfg_layer_o),
    .const_we_o     (const_we_o),
    .ctx_go_o       (ctx_go_o),
    .active_layer_o (active_layer_o),
    .seq_done_o     (seq_done_o)
);

// File: tb/ctx_preloader_test.sv
`timescale 1ns/1ps
module ctx_preloader_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [3:0]  seq_base_i = '0;
    logic [4:0]  seq_len_i = '0;
    logic        exec_done_i = 1'b0;
    logic        cm_rd_en_o;
    logic [10:0] cm_rd_addr_o;
    logic [31:0] cm_rd_data_i = '0;
    logic        cfg_we_o, cfg_layer_o, const_we_o, const_local_o;
    logic [5:0]  cfg_cell_o, const_addr_o;
    logic [23:0] cfg_data_o, const_data_o;
    logic        ctx_go_o, active_layer_o, seq_done_o;

    always #2 clk = ~clk;

    ctx_preloader uut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .seq_base_i(seq_base_i),
        .seq_len_i(seq_len_i), .exec_done_i(exec_done_i),
        .cm_rd_en_o(cm_rd_en_o), .cm_rd_addr_o(cm_rd_addr_o), .cm_rd_data_i(cm_rd_data_i),
        .cfg_we_o(cfg_we_o), .cfg_layer_o(cfg_layer_o), .cfg_cell_o(cfg_cell_o),
        .cfg_data_o(cfg_data_o), .const_we_o(const_we_o), .const_local_o(const_local_o),
        .const_addr_o(const_addr_o), .const_data_o(const_data_o),
        .ctx_go_o(ctx_go_o), .active_layer_o(active_layer_o), .seq_done_o(seq_done_o)
    );

    // Context memory content, computed from the address.
    function automatic logic [31:0] pat(input logic [10:0] a);
        int c = int'(a[10:7]);
        int w = int'(a[6:0]);
        logic [1:0] k = 2'((c * 3 + w) % 4);
        logic [5:0] s = 6'((w * 5 + c) % 64);
        return {k, s, 8'(c), 8'(w), 8'(w ^ 8'h5A)};
    endfunction

    always @(posedge clk) if (cm_rd_en_o) cm_rd_data_i <= pat(cm_rd_addr_o);

    int checks = 0, failures = 0, cyc = 0;
    int rd_total, rd_bad, cfg_n, grf_n, lor_n, layer_bad, go_cnt, done_cnt;
    int unsigned cfg_sum, grf_sum, lor_sum;
    int first_rd, last_rd, first_wr, go_cyc, done_cyc;
    logic [10:0] exp_rd;
    bit finished = 0;

    always @(posedge clk) cyc <= cyc + 1;

    always @(negedge clk) begin
        if (rst_n) begin
            if (cm_rd_en_o) begin
                if (cm_rd_addr_o != exp_rd) rd_bad++;
                exp_rd = exp_rd + 11'd1;
                rd_total++;
                if (first_rd < 0) first_rd = cyc;
                last_rd = cyc;
            end
            if (cfg_we_o || const_we_o) if (first_wr < 0) first_wr = cyc;
            if (cfg_we_o) begin
                cfg_n++;
                cfg_sum += {2'b00, cfg_cell_o, cfg_data_o};
                if (cfg_layer_o == active_layer_o) layer_bad++;
            end
            if (const_we_o && !const_local_o) begin
                grf_n++;
                grf_sum += {2'b01, const_addr_o, const_data_o};
            end
            if (const_we_o && const_local_o) begin
                lor_n++;
                lor_sum += {2'b10, const_addr_o, const_data_o};
            end
            if (ctx_go_o) begin go_cnt++; go_cyc = cyc; end
            if (seq_done_o) begin done_cnt++; done_cyc = cyc; end
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic clr_writes();
        cfg_n = 0; grf_n = 0; lor_n = 0; cfg_sum = 0; grf_sum = 0; lor_sum = 0;
        first_wr = -1; layer_bad = 0;
    endtask

    task automatic clr_all(input logic [10:0] start_addr);
        clr_writes();
        rd_total = 0; rd_bad = 0; first_rd = -1; last_rd = -1;
        exp_rd = start_addr;
    endtask

    task automatic check_ctx(input int c, input string tag);
        int ec = 0, eg = 0, el = 0;
        int unsigned sc = 0, sg = 0, sl = 0;
        for (int w = 0; w < 128; w++) begin
            logic [31:0] v = pat({4'(c), 7'(w)});
            case (v[31:30])
                2'b00: begin ec++; sc += {2'b00, v[29:0]}; end
                2'b01: begin eg++; sg += {2'b00, v[29:0]} | 32'h4000_0000; end
                2'b10: begin el++; sl += {2'b00, v[29:0]} | 32'h8000_0000; end
                default: ;
            endcase
        end
        check(cfg_n == ec, {tag, " R2 cell write count"}, cfg_n, ec);
        check(grf_n == eg, {tag, " R2 global const count"}, grf_n, eg);
        check(lor_n == el, {tag, " R2 local const count"}, lor_n, el);
        check(cfg_sum == sc && grf_sum == sg && lor_sum == sl,
              {tag, " R2 payload sums"}, int'(cfg_sum ^ grf_sum ^ lor_sum), int'(sc ^ sg ^ sl));
        check(layer_bad == 0, {tag, " R3 write to active layer"}, layer_bad, 0);
    endtask

    task automatic do_start(input logic [3:0] base, input logic [4:0] len);
        @(negedge clk); #1;
        start_i = 1'b1; seq_base_i = base; seq_len_i = len;
        @(negedge clk); #1;
        start_i = 1'b0;
    endtask

    task automatic pulse_done(output int drive_cyc);
        @(negedge clk); #1;
        exec_done_i = 1'b1; drive_cyc = cyc;
        @(negedge clk); #1;
        exec_done_i = 1'b0;
    endtask

    task automatic wait_go(input string tag);
        int g0 = go_cnt;
        int n = 0;
        while (go_cnt == g0 && n < 400) begin @(negedge clk); #1; n++; end
        check(go_cnt == g0 + 1, {tag, " R5 swap pulse seen"}, go_cnt, g0 + 1);
    endtask

    task automatic idle_wait(input int n);
        repeat (n) begin @(negedge clk); #1; end
    endtask

    task automatic t_reset();
        check(!cm_rd_en_o && !cfg_we_o && !const_we_o, "R11 no traffic after reset",
              int'(cm_rd_en_o) + int'(cfg_we_o) + int'(const_we_o), 0);
        check(!active_layer_o && !ctx_go_o && !seq_done_o, "R11 layer and pulses low",
              int'(active_layer_o) + int'(ctx_go_o) + int'(seq_done_o), 0);
    endtask

    task automatic t_single();
        int d0, g0;
        clr_all({4'd3, 7'd0});
        g0 = go_cnt;
        do_start(4'd3, 5'd1);
        wait_go("single");
        check(rd_total == 128 && rd_bad == 0, "R1 single reads", rd_total - rd_bad, 128);
        check(first_wr - first_rd == 2, "R4 read to write latency", first_wr - first_rd, 2);
        check(go_cyc - last_rd == 3, "R5 idle swap after last read", go_cyc - last_rd, 3);
        check(active_layer_o == 1'b1, "R5 layer flipped", int'(active_layer_o), 1);
        check_ctx(3, "single");
        idle_wait(4);
        check(done_cnt == 0 && go_cnt == g0 + 1, "R9 no early completion", done_cnt, 0);
        pulse_done(d0);
        check(done_cnt == 1 && done_cyc == d0 + 1, "R9 completion pulse", done_cyc - d0, 1);
        idle_wait(2);
        check(done_cnt == 1, "R9 completion single", done_cnt, 1);
    endtask

    task automatic t_late_done();
        int d0, g1, dc;
        clr_all({4'd5, 7'd0});
        dc = done_cnt;
        do_start(4'd5, 5'd2);
        wait_go("late");
        clr_writes();
        g1 = go_cnt;
        idle_wait(140);
        check(go_cnt == g1, "R5 no swap without finish report", go_cnt, g1);
        check_ctx(6, "late");
        check(rd_total == 256 && rd_bad == 0, "R8 next context fetched", rd_total - rd_bad, 256);
        pulse_done(d0);
        check(go_cnt == g1 + 1 && go_cyc == d0 + 1, "R6 zero gap swap", go_cyc - d0, 1);
        check(active_layer_o == 1'b1, "R6 layer after two swaps", int'(active_layer_o), 1);
        idle_wait(3);
        pulse_done(d0);
        check(done_cnt == dc + 1 && done_cyc == d0 + 1, "R9 completion after final",
              done_cyc - d0, 1);
    endtask

    task automatic t_early_done();
        int d0, gfirst;
        clr_all({4'd0, 7'd0});
        do_start(4'd0, 5'd2);
        wait_go("early");
        gfirst = go_cyc;
        idle_wait(20);
        pulse_done(d0);
        check(go_cyc == gfirst, "R7 no swap mid preload", go_cyc, gfirst);
        wait_go("early2");
        check(go_cyc - gfirst == 130, "R7 remembered finish report", go_cyc - gfirst, 130);
        pulse_done(d0);
        idle_wait(2);
    endtask

    task automatic t_ignore();
        int d0, g0, dc;
        clr_all({4'd2, 7'd0});
        do_start(4'd2, 5'd1);
        idle_wait(10);
        do_start(4'd9, 5'd3);
        wait_go("ignore");
        g0 = go_cnt;
        idle_wait(140);
        check(rd_total == 128 && rd_bad == 0, "R10 busy start ignored", rd_total - rd_bad, 128);
        check(go_cnt == g0, "R10 no extra swap", go_cnt, g0);
        dc = done_cnt;
        pulse_done(d0);
        idle_wait(200);
        check(done_cnt == dc + 1 && go_cnt == g0, "R10 sequence ended once", done_cnt - dc, 1);
        do_start(4'd4, 5'd0);
        idle_wait(20);
        check(rd_total == 128 && go_cnt == g0, "R10 zero length ignored", rd_total, 128);
    endtask

    task automatic t_wrap();
        int d0;
        clr_all({4'd15, 7'd0});
        do_start(4'd15, 5'd2);
        wait_go("wrap");
        clr_writes();
        idle_wait(140);
        check(rd_total == 256 && rd_bad == 0, "R1 index wraps to zero", rd_total - rd_bad, 256);
        check_ctx(0, "wrap");
        pulse_done(d0);
        idle_wait(2);
        pulse_done(d0);
        idle_wait(2);
    endtask

    initial begin
        go_cnt = 0; done_cnt = 0;
        clr_all('0);
        repeat (3) @(negedge clk);
        t_reset();
        #1 rst_n = 1'b1;
        idle_wait(2);
        t_reset();
        t_single();
        t_late_done();
        t_early_done();
        t_ignore();
        t_wrap();
        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule